// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time Insertion

This block produces one pair of complementary gate drive signals, a high-side gate and a low-side gate, from a single period counter. The counter steps only when a prescale tick arrives. It runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Comparing the count against a duty value gives a compare level. A dead-time stage turns that level into two outputs that are never active together, and each output can then be inverted on its own. A one-clock event strobe marks period boundaries, and in triangle mode it can optionally mark the apex as well.

Period and duty come from input ports. The block takes them into shadow registers only at a period boundary, so a running period is never cut short. The dead-time length is read live from its input. A six-bit mode register sets the counting shape, the compare polarity, the event selection, the dead-time enable and the two inversions. Writes to the mode register are refused while either of two protection flags is high. Until the first non-zero period has been taken in, the channel stays idle and both gates sit at their inactive levels.

Top module: `pwm_dt_channel`

## Requirements
- R1: After reset the mode register reads zero. Its bit layout is bit0 = triangle counting, bit1 = compare polarity, bit2 = apex event select, bit3 = dead-time enable, bit4 = invert high gate, bit5 = invert low gate.
- R2: A mode write takes effect at the next clock only when both protection flags are low. If either flag is high, the mode register keeps its value.
- R3: In sawtooth mode (bit0 = 0) with shadow period P, the count goes 0, 1, …, P-1 and then wraps to 0, so a period lasts P ticks.
- R4: In triangle mode (bit0 = 1) the count rises from 0 to P and falls back to 0, so a period lasts 2P ticks.
- R5: The compare level equals the polarity bit while count < shadow duty, and its inverse otherwise. A period with non-zero duty therefore begins at the polarity level.
- R6: An event strobe fires on the tick that ends a period. In triangle mode with bit2 = 1 it also fires on the tick that reaches the apex. In sawtooth mode bit2 has no effect.
- R7: The event strobe is high for exactly one clock and only in the clock after a tick.
- R8: With dead-time disabled, the high gate follows the compare level and the low gate follows its complement. Both are registered, with one clock of latency after a tick.
- R9: With dead-time d enabled, an output turns active in the clock after the d-th tick that follows its raw rise. It turns inactive in the clock after its raw fall. The two raw (pre-inversion) outputs are never active together.
- R10: A raw active phase that lasts d ticks or fewer produces no active pulse at all.
- R11: Bit4 and bit5 invert the high and low gates after the dead-time stage.
- R12: Period and duty inputs are sampled only on the tick that ends a period, or on the first tick while idle. Changes made at any other time wait for the next boundary.
- R13: While the shadow period is zero, both gates hold their inactive levels (the inversion bits) and no event fires. The first tick loads the shadows and starts the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescale tick; counter and dead-time advance only on it |
| periodIn | input | CNT_W | Period value, taken at a boundary |
| dutyIn | input | CNT_W | Duty value, taken at a boundary |
| deadIn | input | DT_W | Dead-time length in ticks |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 6 | Mode register write value |
| wpSoft | input | 1 | Software write-protect flag |
| wpHard | input | 1 | Hardware write-protect flag |
| gateHi | output | 1 | High-side gate |
| gateLo | output | 1 | Low-side gate |
| evtStrobe | output | 1 | Counter event pulse |
| modeOut | output | 6 | Current mode register value |

## Verification
The hardest cases to reach are where dead-time meets short active phases. For example, a small duty in triangle mode, or a duty near the period, gives raw pulses of one or two ticks, which must vanish completely rather than become shortened pulses. The stimulus sweeps every mode value, and then sweeps period, duty and dead-time together in triangle mode, so pulse widths both above and at or below the dead-time are produced. A separate run changes period and duty halfway through a period to show the shadow registers waiting for the boundary.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  localparam int MODE_W = 6;

  // Bit 0 is the lowest field.
  typedef struct packed {
    logic invLo;
    logic invHi;
    logic dtEn;
    logic evtSel;
    logic pol;
    logic align;
  } mode_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clr;
    logic inc;
    logic dec;
    logic load;
  } ctl_t;

  // Counter status from datapath to control.
  typedef struct packed {
    logic idle;
    logic atLast;
    logic atOne;
  } stat_t;
endpackage

// File: rtl/pwm_dt_deadband.sv
module pwm_dt_deadband #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            rawAct,
  input  logic            dtEn,
  input  logic [DT_W-1:0] deadVal,
  output logic            act
);
  logic [DT_W-1:0] dtCnt;

  // The rising edge waits deadVal ticks; the falling edge passes at once.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dtCnt <= '0;
      act   <= 1'b0;
    end else if (!rawAct) begin
      act   <= 1'b0;
      dtCnt <= deadVal;
    end else if (!dtEn || dtCnt == '0) begin
      act <= 1'b1;
    end else if (tick) begin
      dtCnt <= dtCnt - 1'b1;
    end
  end
endmodule

// File: rtl/pwm_dt_ctrl.sv
module pwm_dt_ctrl
  import pwm_dt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWrData,
  input  logic              wpSoft,
  input  logic              wpHard,
  input  stat_t             stat,
  output ctl_t              ctl,
  output mode_t             mode,
  output logic              evtStrobe
);
  logic upQ, upNext, evtNext;
  logic wrOk;

  assign wrOk = modeWrEn && !wpSoft && !wpHard;

  always_ff @(posedge clk) begin
    if (!rstN)     mode <= '0;
    else if (wrOk) mode <= mode_t'(modeWrData);
  end

  always_comb begin
    ctl     = '0;
    evtNext = 1'b0;
    upNext  = upQ;
    if (tick) begin
      if (stat.idle) begin
        ctl.clr  = 1'b1;
        ctl.load = 1'b1;
        upNext   = 1'b1;
      end else if (!mode.align) begin
        upNext = 1'b1;
        if (stat.atLast) begin
          ctl.clr  = 1'b1;
          ctl.load = 1'b1;
          evtNext  = 1'b1;
        end else begin
          ctl.inc = 1'b1;
        end
      end else if (upQ) begin
        ctl.inc = 1'b1;
        if (stat.atLast) begin
          upNext  = 1'b0;
          evtNext = mode.evtSel;
        end
      end else begin
        ctl.dec = 1'b1;
        if (stat.atOne) begin
          ctl.load = 1'b1;
          evtNext  = 1'b1;
          upNext   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ       <= 1'b1;
      evtStrobe <= 1'b0;
    end else begin
      upQ       <= upNext;
      evtStrobe <= evtNext;
    end
  end
endmodule

// File: rtl/pwm_dt_datapath.sv
module pwm_dt_datapath
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  ctl_t             ctl,
  input  mode_t            mode,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [DT_W-1:0]  deadIn,
  output stat_t            stat,
  output logic             gateHi,
  output logic             gateLo
);
  localparam int SIDES = 2;

  logic [CNT_W-1:0] cnt, perQ, dutyQ;
  logic             cmpLvl;
  logic [SIDES-1:0] rawAct, act, invBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      perQ  <= '0;
      dutyQ <= '0;
    end else begin
      if (ctl.clr)      cnt <= '0;
      else if (ctl.inc) cnt <= cnt + 1'b1;
      else if (ctl.dec) cnt <= cnt - 1'b1;
      if (ctl.load) begin
        perQ  <= periodIn;
        dutyQ <= dutyIn;
      end
    end
  end

  assign stat.idle   = (perQ == '0);
  assign stat.atLast = (cnt >= perQ - 1'b1);
  assign stat.atOne  = (cnt == CNT_W'(1));

  assign cmpLvl    = (cnt < dutyQ) ? mode.pol : ~mode.pol;
  assign rawAct[0] = !stat.idle && cmpLvl;
  assign rawAct[1] = !stat.idle && !cmpLvl;
  assign invBits   = {mode.invLo, mode.invHi};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    pwm_dt_deadband #(.DT_W(DT_W)) u_db (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tick),
      .rawAct (rawAct[g]),
      .dtEn   (mode.dtEn),
      .deadVal(deadIn),
      .act    (act[g])
    );
  end

  assign gateHi = act[0] ^ invBits[0];
  assign gateLo = act[1] ^ invBits[1];
endmodule

// File: rtl/pwm_dt_channel.sv
module pwm_dt_channel
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [CNT_W-1:0]  periodIn,
  input  logic [CNT_W-1:0]  dutyIn,
  input  logic [DT_W-1:0]   deadIn,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWrData,
  input  logic              wpSoft,
  input  logic              wpHard,
  output logic              gateHi,
  output logic              gateLo,
  output logic              evtStrobe,
  output logic [MODE_W-1:0] modeOut
);
  ctl_t  ctl;
  stat_t stat;
  mode_t mode;

  pwm_dt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .wpSoft(wpSoft), .wpHard(wpHard),
    .stat(stat), .ctl(ctl), .mode(mode), .evtStrobe(evtStrobe)
  );

  pwm_dt_datapath #(.CNT_W(CNT_W), .DT_W(DT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl), .mode(mode),
    .periodIn(periodIn), .dutyIn(dutyIn), .deadIn(deadIn),
    .stat(stat), .gateHi(gateHi), .gateLo(gateLo)
  );

  assign modeOut = mode;
endmodule

// File: rtl/pwm_dt_channel_chk.sv
module pwm_dt_channel_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       modeWrEn,
  input logic [5:0] modeWrData,
  input logic       wpSoft,
  input logic       wpHard,
  input logic [5:0] modeOut,
  input logic       gateHi,
  input logic       gateLo,
  input logic       evtStrobe
);
  p_mode_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> modeOut == 6'd0);

  p_wp_block_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && (wpSoft || wpHard)) |=> $stable(modeOut));

  p_wr_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && !wpSoft && !wpHard) |=> modeOut == $past(modeWrData));

  p_evt_after_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtStrobe |-> $past(tick));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!modeOut[4] && !modeOut[5]) |-> !(gateHi && gateLo));
endmodule

bind pwm_dt_channel pwm_dt_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .modeWrEn(modeWrEn),
  .modeWrData(modeWrData), .wpSoft(wpSoft), .wpHard(wpHard),
  .modeOut(modeOut), .gateHi(gateHi), .gateLo(gateLo),
  .evtStrobe(evtStrobe)
);

// File: tb/pwm_dt_channel_bench.sv
module pwm_dt_channel_bench;
  localparam int CW = 8;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, tick = 1'b0, modeWrEn = 1'b0, wpSoft = 1'b0, wpHard = 1'b0;
  logic [CW-1:0] periodIn = '0, dutyIn = '0;
  logic [DW-1:0] deadIn = '0;
  logic [5:0] modeWrData = '0, modeOut;
  logic gateHi, gateLo, evtStrobe;

  int checks = 0, errors = 0;
  int ph, curP, curD, runHi, runLo;
  string reqOverride = "";

  always #4 clk = ~clk;

  pwm_dt_channel #(.CNT_W(CW), .DT_W(DW)) u_pwm_dt_channel (
    .clk(clk), .rstN(rstN), .tick(tick), .periodIn(periodIn), .dutyIn(dutyIn),
    .deadIn(deadIn), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .wpSoft(wpSoft), .wpHard(wpHard), .gateHi(gateHi), .gateLo(gateLo),
    .evtStrobe(evtStrobe), .modeOut(modeOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; tick = 1'b0; modeWrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeMode(input logic [5:0] m);
    @(negedge clk);
    modeWrEn = 1'b1; modeWrData = m;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  // One tick; model advanced with the inputs present at the tick edge.
  task automatic doTick(input bit first, input logic [5:0] m);
    bit evtExp, oc, expHi, expLo;
    int len, cnt;
    string rq;
    @(negedge clk);
    tick = 1'b1;
    evtExp = 1'b0;
    if (first) begin
      curP = int'(periodIn); curD = int'(dutyIn); ph = 0;
    end else begin
      ph++;
      len = m[0] ? 2 * curP : curP;
      if (ph == len) begin
        ph = 0; evtExp = 1'b1;
        curP = int'(periodIn); curD = int'(dutyIn);
      end else if (m[0] && m[2] && ph == curP) begin
        evtExp = 1'b1;
      end
    end
    cnt = (m[0] && ph > curP) ? 2 * curP - ph : ph;
    oc = (cnt < curD) ? m[1] : !m[1];
    runHi = oc ? runHi + 1 : 0;
    runLo = oc ? 0 : runLo + 1;
    expHi = m[3] ? (runHi > int'(deadIn)) : oc;
    expLo = m[3] ? (runLo > int'(deadIn)) : !oc;
    @(negedge clk);
    tick = 1'b0;
    chk(evtStrobe == evtExp, "R6", int'(evtStrobe), int'(evtExp));
    @(negedge clk);
    chk(evtStrobe == 1'b0, "R7", int'(evtStrobe), 0);
    if (reqOverride != "") rq = reqOverride;
    else if (m[5:4] != 2'b00) rq = "R11";
    else if (m[3]) rq = "R9";
    else rq = m[0] ? "R4" : "R3";
    chk(gateHi == (expHi ^ m[4]), rq, int'(gateHi), int'(expHi ^ m[4]));
    chk(gateLo == (expLo ^ m[5]), rq, int'(gateLo), int'(expLo ^ m[5]));
    if (first && m[5:3] == 3'b000 && curD > 0)
      chk(gateHi == m[1], "R5", int'(gateHi), int'(m[1]));
    if (m[5:3] == 3'b000)
      chk(gateLo == !gateHi, "R8", int'(gateLo), int'(!gateHi));
  endtask

  task automatic runConfig(input logic [5:0] m, input int p, input int d, input int dt,
                           input int nTicks);
    doReset();
    periodIn = CW'(p); dutyIn = CW'(d); deadIn = DW'(dt);
    runHi = 0; runLo = 0;
    writeMode(m);
    chk(modeOut == m, "R2", int'(modeOut), int'(m));
    @(negedge clk);
    chk(gateHi == m[4] && gateLo == m[5] && !evtStrobe, "R13",
        int'({gateHi, gateLo}), int'({m[4], m[5]}));
    doTick(1'b1, m);
    for (int i = 0; i < nTicks; i++) doTick(1'b0, m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    chk(modeOut == 6'd0, "R1", int'(modeOut), 0);
    chk(gateHi == 1'b0 && gateLo == 1'b0, "R13", int'({gateHi, gateLo}), 0);

    // Write protection
    wpSoft = 1'b1; writeMode(6'h15);
    chk(modeOut == 6'd0, "R2", int'(modeOut), 0);
    wpSoft = 1'b0; wpHard = 1'b1; writeMode(6'h2A);
    chk(modeOut == 6'd0, "R2", int'(modeOut), 0);
    wpHard = 1'b0; writeMode(6'h2A);
    chk(modeOut == 6'h2A, "R2", int'(modeOut), 32'h2A);

    // Every mode value
    for (int m = 0; m < 64; m++)
      runConfig(6'(m), 2 + m % 3, m % 5, m % 4, 4 * (2 + m % 3) + 3);

    // Triangle with dead-time over period, duty and dead-time
    for (int p = 1; p <= 4; p++)
      for (int d = 0; d <= 5; d++)
        for (int dt = 0; dt <= 3; dt++)
          runConfig(6'b001101, p, d, dt, 4 * p + 2);

    // Short pulse removed
    reqOverride = "R10";
    runConfig(6'b001000, 6, 4, 3, 12);
    reqOverride = "";

    // Mid-period change of period and duty
    reqOverride = "R12";
    doReset();
    periodIn = 8'd4; dutyIn = 8'd2; deadIn = '0; runHi = 0; runLo = 0;
    writeMode(6'b000000);
    doTick(1'b1, 6'b000000);
    doTick(1'b0, 6'b000000);
    periodIn = 8'd6; dutyIn = 8'd5;
    for (int i = 0; i < 14; i++) doTick(1'b0, 6'b000000);
    reqOverride = "";

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule